// File: doc/BRIEF.md
# Slot-Indexed Fixed-Latency Delay Line

The block returns every accepted data word on its output exactly `DELAY` clock cycles after it arrived, unchanged. Wide words are not marched through a chain of registers. Each accepted word is written once into a free storage slot and stays there. Only a valid flag and the slot number travel down a `DELAY`-stage shift register. When a flag reaches the final stage, the slot number it carries selects the stored word for the output, and that slot is returned to the free pool in the same cycle.

Allocation is a find-first search over the free slots, and the lowest-numbered free slot wins. A slot being released in a cycle counts as free in that cycle, so it can take a new word straight away. The storage holds `SLOTS >= DELAY` entries, so an input that arrives on every cycle always finds room. There is no backpressure, and the latency is fixed when the block is elaborated. Typical use is to align a wide data path with a slower parallel computation where the data toggles often.

Top module: `slot_delay_line`

## Requirements
- R1: While reset is held, and after it is released until a new word has had time to pass through, `out_vld_o` is 0 and `out_data_o` is all zeros.
- R2: A word presented with `in_vld_i` = 1 in cycle c appears on `out_data_o` with `out_vld_o` = 1 in cycle c + `DELAY`, bit for bit equal.
- R3: A cycle with `in_vld_i` = 0 produces a cycle with `out_vld_o` = 0 exactly `DELAY` cycles later, whatever value `in_data_i` had.
- R4: With `in_vld_i` held at 1 on every cycle for an unbounded run, no word is dropped or corrupted. A slot released at the output in a cycle is reusable by the input in that cycle, and allocation takes the lowest-numbered free slot.
- R5: Under any mix of valid and idle cycles, words leave in arrival order with their idle gaps preserved.
- R6: Reset asserted while words are in flight discards them all, and none of them ever reaches the output.
- R7: `out_data_o` is all zeros in every cycle in which `out_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input word valid |
| in_data_i | input | DATA_W | Input word |
| out_vld_o | output | 1 | Delayed word valid |
| out_data_o | output | DATA_W | Delayed word, zero when not valid |

## Verification
A corrupted slot number or storage entry can only show up in the one cycle when its word leaves. That cycle is exactly `DELAY` cycles after the word entered, and the output then carries a different word, a stale word, or a missing valid. A slot that is never freed produces nothing at the ports until the pool runs dry. Only a long full-rate burst reaches that point, so the bench drives such a burst, and the internal checks compare the count of occupied slots with the count of flags in flight on every cycle. Mid-stream reset and the zero-data rule catch leftover state on the first idle cycles after it.

// File: rtl/slot_dly_pkg.sv
package slot_dly_pkg;

   // width of a slot index, never below one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/slot_dly_alloc.sv
module slot_dly_alloc #(
   parameter int unsigned SLOTS = 4,
   parameter int unsigned ID_W  = 2
) (
   input  logic [SLOTS-1:0] avail_i,
   output logic             found_o,
   output logic [ID_W-1:0]  slot_o
);

   // scan downward so the lowest set bit is the last one kept
   always_comb begin
      found_o = 1'b0;
      slot_o  = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (avail_i[i]) begin
            found_o = 1'b1;
            slot_o  = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/slot_dly_pipe.sv
module slot_dly_pipe #(
   parameter int unsigned DELAY = 4,
   parameter int unsigned ID_W  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_vld_i,
   input  logic [ID_W-1:0]  push_id_i,
   output logic             pop_vld_o,
   output logic [ID_W-1:0]  pop_id_o,
   output logic [DELAY-1:0] occ_o
);

   logic [DELAY-1:0]           vld_q;
   logic [DELAY-1:0][ID_W-1:0] id_q;

   if (DELAY == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q <= '0;
            id_q  <= '0;
         end else begin
            vld_q[0] <= push_vld_i;
            if (push_vld_i) id_q[0] <= push_id_i;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q <= '0;
            id_q  <= '0;
         end else begin
            vld_q <= {vld_q[DELAY-2:0], push_vld_i};
            if (push_vld_i) id_q[0] <= push_id_i;
            // an ID stage only loads when a live entry moves into it
            for (int s = 1; s < DELAY; s++) begin
               if (vld_q[s-1]) id_q[s] <= id_q[s-1];
            end
         end
      end
   end

   assign pop_vld_o = vld_q[DELAY-1];
   assign pop_id_o  = id_q[DELAY-1];
   assign occ_o     = vld_q;

endmodule

// File: rtl/slot_dly_store.sv
module slot_dly_store #(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ID_W-1:0]   wr_id_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rel_en_i,
   input  logic [ID_W-1:0]   rel_id_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [SLOTS-1:0]  busy_o
);

   logic [DATA_W-1:0] mem_q [SLOTS];
   logic [SLOTS-1:0]  busy_q;

   // occupancy: a write wins over a release of the same slot
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= '0;
      end else begin
         for (int k = 0; k < SLOTS; k++) begin
            if (wr_en_i && (wr_id_i == ID_W'(k)))       busy_q[k] <= 1'b1;
            else if (rel_en_i && (rel_id_i == ID_W'(k))) busy_q[k] <= 1'b0;
         end
      end
   end

   // payload storage, written once per word and never shifted
   always_ff @(posedge clk_i) begin
      for (int k = 0; k < SLOTS; k++) begin
         if (wr_en_i && (wr_id_i == ID_W'(k))) mem_q[k] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[rel_id_i];
   assign busy_o    = busy_q;

endmodule

// File: rtl/slot_delay_line.sv
module slot_delay_line #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DELAY  = 5,
   parameter int unsigned SLOTS  = DELAY
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_vld_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              out_vld_o,
   output logic [DATA_W-1:0] out_data_o
);

   localparam int unsigned ID_W = slot_dly_pkg::idx_width(SLOTS);

   if (DELAY < 1) begin : g_bad_delay
      $error("slot_delay_line: DELAY must be at least 1");
   end
   if (SLOTS < DELAY) begin : g_bad_slots
      $error("slot_delay_line: SLOTS must be at least DELAY");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("slot_delay_line: DATA_W must be at least 1");
   end

   logic [SLOTS-1:0]  busy;
   logic [SLOTS-1:0]  rel_mask;
   logic [SLOTS-1:0]  avail;
   logic              found;
   logic [ID_W-1:0]   slot;
   logic              pop_vld;
   logic [ID_W-1:0]   pop_id;
   logic [DELAY-1:0]  occ;
   logic [DATA_W-1:0] rd_data;
   logic              accept;

   // a slot leaving this cycle is offered to the input this cycle
   always_comb begin
      rel_mask = '0;
      for (int k = 0; k < SLOTS; k++) begin
         rel_mask[k] = pop_vld && (pop_id == ID_W'(k));
      end
   end
   assign avail  = ~busy | rel_mask;
   assign accept = in_vld_i && found;

   slot_dly_alloc #(.SLOTS(SLOTS), .ID_W(ID_W)) alloc_i (
      .avail_i (avail),
      .found_o (found),
      .slot_o  (slot)
   );

   slot_dly_pipe #(.DELAY(DELAY), .ID_W(ID_W)) pipe_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_vld_i (accept),
      .push_id_i  (slot),
      .pop_vld_o  (pop_vld),
      .pop_id_o   (pop_id),
      .occ_o      (occ)
   );

   slot_dly_store #(.SLOTS(SLOTS), .DATA_W(DATA_W), .ID_W(ID_W)) store_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (accept),
      .wr_id_i   (slot),
      .wr_data_i (in_data_i),
      .rel_en_i  (pop_vld),
      .rel_id_i  (pop_id),
      .rd_data_o (rd_data),
      .busy_o    (busy)
   );

   assign out_vld_o  = pop_vld;
   assign out_data_o = pop_vld ? rd_data : '0;

   AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (busy == '0) && !out_vld_o); // R1

   AST_OCC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(busy) == $countones(occ)); // R2

   AST_POP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_vld_o |-> busy[pop_id]); // R2

   AST_SLOT_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_vld_i |-> found); // R4

   AST_ALLOC_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found |-> ((avail & ((SLOTS'(1) << slot) - SLOTS'(1))) == '0)); // R4

endmodule

// File: tb/slot_delay_line_tb.sv
module slot_delay_line_tb_top;

   localparam int unsigned DW  = 32;
   localparam int unsigned DLY = 5;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          in_vld = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_vld;
   logic [DW-1:0] out_data;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   string tag    = "R1";

   logic          hv [$];
   logic [DW-1:0] hd [$];

   always #5 clk = ~clk;

   slot_delay_line #(.DATA_W(DW), .DELAY(DLY)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .in_vld_i   (in_vld),
      .in_data_i  (in_data),
      .out_vld_o  (out_vld),
      .out_data_o (out_data)
   );

   task automatic check_now();
      logic          ev = 1'b0;
      logic [DW-1:0] ed = '0;
      if (hv.size() == DLY) begin
         ev = hv[0];
         ed = hd[0];
      end
      n_chk++;
      if (out_vld !== ev) begin
         n_fail++;
         $display("FAIL %s out_vld actual=%b expected=%b", tag, out_vld, ev);
      end
      n_chk++;
      if (ev && out_data !== ed) begin
         n_fail++;
         $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, ed);
      end else if (!ev && out_data !== '0) begin
         n_fail++; // R7
         $display("FAIL R7 idle out_data actual=%h expected=%h", out_data, {DW{1'b0}});
      end
   endtask

   // one clock: check the cycle just entered, then drive the next inputs
   task automatic cyc(input logic rst, input logic v, input logic [DW-1:0] d);
      @(negedge clk);
      check_now();
      rst_ni  = rst;
      in_vld  = v;
      in_data = d;
      if (!rst) begin
         hv.delete();
         hd.delete();
      end else begin
         hv.push_back(v);
         hd.push_back(d);
         if (hv.size() > DLY) begin
            void'(hv.pop_front());
            void'(hd.pop_front());
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      // R1: outputs quiet through reset and the idle cycles after it
      tag = "R1";
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0);
      for (int i = 0; i < DLY + 3; i++) cyc(1'b1, 1'b0, $urandom);

      // R2: lone words reach the output DLY cycles later, unchanged
      tag = "R2";
      cyc(1'b1, 1'b1, 32'hA5A5_0001);
      for (int i = 0; i < DLY + 2; i++) cyc(1'b1, 1'b0, '0);
      cyc(1'b1, 1'b1, 32'hFFFF_FFFF);
      cyc(1'b1, 1'b0, '0);
      cyc(1'b1, 1'b1, 32'h0000_0000);
      for (int i = 0; i < DLY + 2; i++) cyc(1'b1, 1'b0, '0);

      // R3: data toggling while invalid must not surface
      tag = "R3";
      for (int i = 0; i < 3 * DLY; i++) cyc(1'b1, (i % 4) == 0, $urandom);

      // R4: back-to-back words on every cycle, slots recycled in place
      tag = "R4";
      for (int i = 0; i < 60; i++) cyc(1'b1, 1'b1, $urandom);
      for (int i = 0; i < DLY + 1; i++) cyc(1'b1, 1'b0, '0);

      // R5: irregular valid pattern keeps order and gaps
      tag = "R5";
      for (int i = 0; i < 300; i++) cyc(1'b1, $urandom_range(0, 2) != 0, $urandom);

      // R6: reset in flight throws away every pending word
      tag = "R6";
      for (int i = 0; i < DLY - 1; i++) cyc(1'b1, 1'b1, $urandom);
      cyc(1'b0, 1'b0, '0);
      cyc(1'b0, 1'b0, '0);
      for (int i = 0; i < DLY + 3; i++) cyc(1'b1, 1'b0, $urandom);
      cyc(1'b1, 1'b1, 32'h1234_5678);
      for (int i = 0; i < DLY + 2; i++) cyc(1'b1, 1'b0, '0);

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", tag);
      finish_run();
   end

endmodule